// File: doc/BRIEF.md
# Hall-Period Commutation Phase Timer

This block times one Hall sensor signal against the system clock and turns that measurement into an adaptive angle scale. It counts clock cycles between consecutive rising edges of the reference Hall input and keeps the most recent count. That count, divided by 960, sets the spacing of a commutation tick. A position counter moves one step per tick, so one Hall period spans 960 steps.

At selected Hall edges the position counter is reloaded with a signed phase offset. The offset can move the commutation angle ahead of the Hall transition or behind it. In basic three-Hall mode the offset is not used. Reloading happens only every N rising edges, so between reloads the counter runs freely and wraps around.

The Hall input must already be synchronized and deglitched. The other two Hall lines feed the downstream commutation tables, not this block. Deasserting the enable input returns all timing state to zero.

Top module: `hall_comm_timer`

## Requirements
- R1: `hall_period` equals the number of clock cycles between the two most recent rising edges of `hall_ref`. It is updated at the clock edge where a rising edge is detected, that is, the first clock where `hall_ref` is 1 after being 0. It reads zero until the second rising edge after enable, and it does not change at any other time.
- R2: While `hall_period` is zero, `comm_tick` stays low.
- R3: When `hall_period` is nonzero, `comm_tick` is a one-cycle pulse every max(floor(`hall_period`/960),1) clocks, and its spacing restarts at each rising edge. With a steady period P that is a multiple of 960, exactly 960 ticks fall within every P clocks.
- R4: Outside reload edges, `comm_pos` increases by one at the clock after each tick and wraps from 959 to 0. Without a tick it holds, and it always stays below 960.
- R5: At a reload edge with `phase_delay`=0 and `basic_mode`=0, `comm_pos` loads `phase_ofs`.
- R6: At a reload edge with `phase_delay`=1 and `basic_mode`=0, `comm_pos` loads (960 − `phase_ofs`) mod 960.
- R7: With `basic_mode`=1, a reload edge loads 0 and `phase_ofs` and `phase_delay` have no effect. Ticks still advance the position.
- R8: Reload edges are every N-th rising edge, with N = 2^`resync_sel` (0→1, 1→2, 2→4, 3→8). The first rising edge after enable is always a reload edge. At a reload edge, the reload takes priority over a coincident tick. A changed offset has no effect until the next reload edge.
- R9: The period counter stops at all ones and `stall` is then high. The next rising edge latches the all-ones count into `hall_period` and clears `stall`.
- R10: `rst_n` low, or `enable` low at a clock edge, clears `comm_pos`, `hall_period`, `stall`, `comm_tick` and the edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low clears all timing state |
| hall_ref | input | 1 | Synchronized, deglitched reference Hall signal |
| phase_ofs | input | OFS_W (8) | Phase offset in commutation steps |
| phase_delay | input | 1 | 1: offset delays commutation, 0: offset advances it |
| resync_sel | input | 2 | Reload interval select, N = 2^value Hall edges |
| basic_mode | input | 1 | Basic 120-degree mode, offset ignored |
| comm_pos | output | POS_W (10) | Commutation position, 0..959 |
| comm_tick | output | 1 | One-cycle commutation step pulse |
| hall_period | output | PER_W (25) | Latched Hall period in clock cycles |
| stall | output | 1 | Period counter saturated |

## Verification
The bench checks the gap between the first and second Hall edges. A design that generated ticks from a zero period, or latched a period on the first edge, would show stray ticks or a wrong `hall_period` there. It also tests a reload that coincides with a tick: letting the tick win would leave the position one step past the offset. It checks the delayed offset at zero, which a bare 960 − offset would push out of range to 960. It changes the offset between reload edges with N of 2 and 4, where resynchronizing on every edge would show the new value too early. It checks the exact wrap from 959 to 0. Finally it holds the Hall input still until the narrowed period counter saturates, so a counter that wrapped instead of stopping would drop `stall` and latch a small period.

// File: rtl/hall_comm_timer.sv
module hall_comm_timer #(
  parameter int PER_W = 25,
  parameter int OFS_W = 8,
  parameter int STEPS = 960,
  localparam int POS_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             hall_ref,
  input  logic [OFS_W-1:0] phase_ofs,
  input  logic             phase_delay,
  input  logic [1:0]       resync_sel,
  input  logic             basic_mode,
  output logic [POS_W-1:0] comm_pos,
  output logic             comm_tick,
  output logic [PER_W-1:0] hall_period,
  output logic             stall
);

  localparam int TICK_W = PER_W - 8;

  logic              hall_q, seen, rise, lat, resync, valid;
  logic [PER_W-1:0]  per_cnt, div_src, div_full;
  logic [TICK_W-1:0] tick_cnt, div_val, reload;
  logic [2:0]        edge_cnt, edge_mask;
  logic [POS_W-1:0]  load_val, step_val;

  assign rise      = enable & hall_ref & ~hall_q;
  assign lat       = rise & seen;
  assign stall     = &per_cnt;
  assign valid     = |hall_period;
  assign comm_tick = valid && (tick_cnt == '0);

  assign div_src  = lat ? per_cnt : hall_period;
  assign div_full = div_src / PER_W'(STEPS);
  assign div_val  = TICK_W'(div_full);
  assign reload   = (div_val == '0) ? '0 : div_val - 1'b1;

  assign edge_mask = (3'd1 << resync_sel) - 3'd1;
  assign resync    = rise && ((edge_cnt & edge_mask) == 3'd0);

  always_comb begin
    if (basic_mode)
      load_val = '0;
    else if (phase_delay && (phase_ofs != '0))
      load_val = POS_W'(STEPS) - POS_W'(phase_ofs);
    else if (phase_delay)
      load_val = '0;
    else
      load_val = POS_W'(phase_ofs);
  end

  assign step_val = (comm_pos == POS_W'(STEPS - 1)) ? '0 : comm_pos + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hall_q      <= 1'b0;
      seen        <= 1'b0;
      per_cnt     <= '0;
      hall_period <= '0;
      tick_cnt    <= '0;
      edge_cnt    <= '0;
      comm_pos    <= '0;
    end else begin
      hall_q <= hall_ref;
      if (!enable) begin
        seen        <= 1'b0;
        per_cnt     <= '0;
        hall_period <= '0;
        tick_cnt    <= '0;
        edge_cnt    <= '0;
        comm_pos    <= '0;
      end else begin
        if (rise) begin
          per_cnt <= PER_W'(1);
          seen    <= 1'b1;
        end else if (!stall) begin
          per_cnt <= per_cnt + 1'b1;
        end

        if (lat)
          hall_period <= per_cnt;

        if (rise || comm_tick)
          tick_cnt <= reload;
        else if (tick_cnt != '0)
          tick_cnt <= tick_cnt - 1'b1;

        if (rise)
          edge_cnt <= (edge_cnt + 3'd1) & edge_mask;

        if (resync)
          comm_pos <= load_val;
        else if (comm_tick)
          comm_pos <= step_val;
      end
    end
  end

endmodule

// File: rtl/hall_comm_timer_chk.sv
module hall_comm_timer_chk #(
  parameter int PER_W = 25,
  parameter int STEPS = 960,
  parameter int POS_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             hall_ref,
  input logic [1:0]       resync_sel,
  input logic             basic_mode,
  input logic [POS_W-1:0] comm_pos,
  input logic             comm_tick,
  input logic [PER_W-1:0] hall_period,
  input logic             stall
);

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    comm_pos < POS_W'(STEPS)); // R4

  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_period == '0) |-> !comm_tick); // R2

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (comm_pos == '0 && hall_period == '0 && !comm_tick && !stall)); // R10

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && comm_tick && !(hall_ref && !$past(hall_ref)))
    |=> comm_pos == (($past(comm_pos) == POS_W'(STEPS - 1)) ? '0 : $past(comm_pos) + 1'b1)); // R4

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !comm_tick && !(hall_ref && !$past(hall_ref))) |=> $stable(comm_pos)); // R4

  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !(hall_ref && !$past(hall_ref))) |=> $stable(hall_period)); // R1

  AST_BASIC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && basic_mode && resync_sel == 2'd0 && hall_ref && !$past(hall_ref))
    |=> comm_pos == '0); // R7

endmodule

bind hall_comm_timer hall_comm_timer_chk #(
  .PER_W(PER_W), .STEPS(STEPS), .POS_W(POS_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .hall_ref(hall_ref),
  .resync_sel(resync_sel), .basic_mode(basic_mode), .comm_pos(comm_pos),
  .comm_tick(comm_tick), .hall_period(hall_period), .stall(stall)
);

// File: tb/hall_comm_timer_tb.sv
`timescale 1ns/1ps
module hall_comm_timer_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int PW = 16;
  localparam int P  = 1920;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, hall_ref = 1'b0;
  logic [7:0] phase_ofs = '0;
  logic phase_delay = 1'b0, basic_mode = 1'b0;
  logic [1:0] resync_sel = '0;
  logic [9:0] comm_pos;
  logic comm_tick, stall;
  logic [PW-1:0] hall_period;

  int n_chk = 0, n_bad = 0, ticks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hall_comm_timer #(.PER_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hall_ref(hall_ref),
    .phase_ofs(phase_ofs), .phase_delay(phase_delay), .resync_sel(resync_sel),
    .basic_mode(basic_mode), .comm_pos(comm_pos), .comm_tick(comm_tick),
    .hall_period(hall_period), .stall(stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (comm_tick) ticks++;
  endtask

  task automatic edge_up();
    hall_ref = 1'b1;
    step();
  endtask

  task automatic advance(input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      if (i >= P/2 - 1) hall_ref = 1'b0;
      step();
    end
  endtask

  task automatic finish_period(input int from);
    advance(from, P - 1);
  endtask

  task automatic t_reset();
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R10 reset comm_pos", comm_pos, 0);
    chk("R10 reset hall_period", hall_period, 0);
    chk("R10 reset comm_tick", comm_tick, 0);
    chk("R10 reset stall", stall, 0);
    phase_ofs = 8'd10; enable = 1'b1;
    step();
  endtask

  task automatic t_first_edges();
    edge_up();
    chk("R5 first edge loads offset", comm_pos, 10);
    chk("R1 period zero after one edge", hall_period, 0);
    ticks = 0;
    finish_period(0);
    edge_up();
    chk("R2 no ticks before second edge", ticks, 0);
    chk("R1 period after second edge", hall_period, P);
    chk("R8 reload beats tick", comm_pos, 10);
  endtask

  task automatic t_tick_rate();
    ticks = 0;
    finish_period(0);
    edge_up();
    chk("R3 ticks per period", ticks, 960);
    chk("R5 advance reload", comm_pos, 10);
    step();
    chk("R3 tick spacing restart", comm_tick, 1);
    chk("R4 position before step", comm_pos, 10);
    step();
    chk("R4 position after one tick", comm_pos, 11);
    finish_period(2);
  endtask

  task automatic t_delay();
    phase_delay = 1'b1;
    edge_up();
    chk("R6 delayed reload", comm_pos, 950);
    finish_period(0);
    phase_ofs = 8'd0;
    edge_up();
    chk("R6 delay with zero offset", comm_pos, 0);
    finish_period(0);
  endtask

  task automatic t_basic();
    phase_ofs = 8'd20; phase_delay = 1'b0; basic_mode = 1'b1;
    edge_up();
    chk("R7 basic mode ignores offset", comm_pos, 0);
    step(); step();
    chk("R7 basic mode still ticks", comm_pos, 1);
    finish_period(2);
    basic_mode = 1'b0;
  endtask

  task automatic t_resync_two();
    resync_sel = 2'd1; phase_ofs = 8'd10;
    edge_up();
    chk("R8 N=2 reload edge", comm_pos, 10);
    advance(0, 1898);
    chk("R4 reaches 959", comm_pos, 959);
    advance(1898, 1899);
    chk("R4 holds 959 between ticks", comm_pos, 959);
    advance(1899, 1900);
    chk("R4 wraps to 0", comm_pos, 0);
    phase_ofs = 8'd30;
    finish_period(1900);
    edge_up();
    chk("R8 offset ignored on non-reload edge", comm_pos, 10);
    finish_period(0);
    edge_up();
    chk("R8 new offset on next reload edge", comm_pos, 30);
    finish_period(0);
  endtask

  task automatic t_enable_clear();
    enable = 1'b0;
    step();
    chk("R10 disable clears comm_pos", comm_pos, 0);
    chk("R10 disable clears hall_period", hall_period, 0);
    chk("R10 disable clears comm_tick", comm_tick, 0);
    step();
    enable = 1'b1; resync_sel = 2'd2; phase_ofs = 8'd40;
    step();
    edge_up();
    chk("R8 first edge after enable reloads", comm_pos, 40);
    chk("R10 period cleared by disable", hall_period, 0);
    phase_ofs = 8'd50;
    finish_period(0);
    edge_up();
    chk("R8 N=4 edge two", comm_pos, 40);
    finish_period(0);
    edge_up();
    finish_period(0);
    edge_up();
    chk("R8 N=4 edge four", comm_pos, 40);
    finish_period(0);
    edge_up();
    chk("R8 N=4 edge five reloads", comm_pos, 50);
  endtask

  task automatic t_stall();
    advance(0, 65533);
    chk("R9 no stall before saturation", stall, 0);
    step();
    chk("R9 stall at saturation", stall, 1);
    repeat (10) step();
    chk("R9 stall persists", stall, 1);
    chk("R9 period held during stall", hall_period, P);
    edge_up();
    chk("R9 edge clears stall", stall, 0);
    chk("R9 saturated period latched", hall_period, 65535);
  endtask

  initial begin
    t_reset();
    t_first_edges();
    t_tick_rate();
    t_delay();
    t_basic();
    t_resync_two();
    t_enable_clear();
    t_stall();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule